// File: doc/BRIEF.md
# Per-Channel Packet Length Checker

This block sits beside a 32-bit packet stream. Every beat of the stream carries a logical channel number, start and end markers, and a byte count for the final beat. The block adds up the bytes of each packet from its start beat to its end beat. Packets on different channels may interleave at burst boundaries, so a partial length is kept for each channel and picked up again when that channel's next beat arrives.

When a packet ends, its length is compared with two limits held for its channel: a minimum of 0 to 255 bytes and a maximum of 0 to 16,383 bytes. One cycle after the end beat, a result strobe reports the channel and whether the packet was too short or too long. If the channel's count enable is set, the matching 16-bit error counter for that channel also increments.

The stream itself is passed on unaltered, one register stage later. A small register port lets software program the limits and the enable, read the counters, and clear them. There are 256 channels.

Top module: `pkt_len_checker`

## Requirements
- R1: A finished packet whose length is strictly less than its channel's minimum (config word bits [7:0]) raises `res_short` on its result strobe.
- R2: A finished packet whose length is strictly greater than its channel's maximum (config word bits [21:8]) raises `res_long` on its result strobe.
- R3: A length exactly equal to the minimum or to the maximum raises no flag.
- R4: Packet length is 4 bytes for each beat that does not carry `in_eop`, plus `in_bcnt`+1 bytes (1 to 4) on the end beat. A beat with `in_sop` discards any length already gathered on that channel.
- R5: Each channel keeps its own partial length, so beats of packets on other channels may arrive between the beats of one packet without changing its measured length.
- R6: A channel's short or long counter increments for a flagged packet only when that channel's enable (config word bit 22) is 1. The result flags are reported whatever the enable is.
- R7: Each counter is 16 bits wide and holds at 65535 instead of wrapping.
- R8: A register write to a counter address clears that counter. If an increment to the same counter falls in the same cycle, the clear wins.
- R9: `res_valid` is high for exactly one cycle, the cycle after each beat that has both `in_valid` and `in_eop`. It carries that beat's channel in `res_chan`. When `res_valid` is low, `res_short` and `res_long` are 0.
- R10: `out_*` repeat `in_*` unchanged, one clock cycle later.
- R11: After reset, every limit, enable, counter and partial length is 0, and no strobe is raised.
- R12: Register address bits [9:8] select the config word (0), the short counter (1) or the long counter (2); selector 3 reads as 0. Address bits [7:0] select the channel. `reg_rdata` is loaded in the cycle after `reg_rd` and holds its value otherwise. A read returns the value from before any update made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_bcnt | input | 2 | Valid bytes on the end beat, minus one |
| in_chan | input | 8 | Logical channel of the beat |
| in_data | input | 32 | Beat payload |
| out_valid | output | 1 | Delayed `in_valid` |
| out_sop | output | 1 | Delayed `in_sop` |
| out_eop | output | 1 | Delayed `in_eop` |
| out_bcnt | output | 2 | Delayed `in_bcnt` |
| out_chan | output | 8 | Delayed `in_chan` |
| out_data | output | 32 | Delayed `in_data` |
| res_valid | output | 1 | Check result strobe |
| res_chan | output | 8 | Channel of the checked packet |
| res_short | output | 1 | Packet was below the minimum |
| res_long | output | 1 | Packet was above the maximum |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Selector (bits 9:8) and channel (bits 7:0) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |

## Verification
The bench aims at the edges of the length range:
- lengths one byte below, exactly at, and one byte above each limit, where an off-by-one comparison would flag a packet that passes or pass one that should be flagged;
- the largest maximum, 16,383, against a 16,384-byte packet, which catches a length register too narrow to hold it;
- beats of two channels interleaved, which exposes a single shared accumulator by mixing their lengths;
- more than 65,535 short packets on one channel, where a wrapping counter would return to a small value;
- a channel with its enable clear, and clears of counters read back afterwards, which shows a counter that ignores its enable or that a write fails to reset.

// File: rtl/pl_pkg.sv
package pl_pkg;

    localparam int NUM_CH     = 256;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int DATA_W     = 32;
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BC_W       = $clog2(BEAT_BYTES);
    localparam int MIN_W      = 8;
    localparam int MAX_W      = 14;
    localparam int LEN_W      = MAX_W + 1;
    localparam int CNT_W      = 16;
    localparam int ADDR_W     = CH_W + 2;
    localparam int EN_BIT     = MIN_W + MAX_W;

    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_SHORT = 2'd1,
        SEL_LONG  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_t;

    typedef struct packed {
        logic             en;
        logic [MAX_W-1:0] max_len;
        logic [MIN_W-1:0] min_len;
    } ch_cfg_t;

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic              eop;
        logic [BC_W-1:0]   bcnt;
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] data;
    } beat_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] chan;
        logic            is_short;
        logic            is_long;
    } chk_res_t;

    // Bytes carried by one beat: full width unless it ends the packet.
    function automatic logic [BC_W:0] beat_bytes(input logic eop, input logic [BC_W-1:0] bcnt);
        logic [BC_W:0] n;
        if (eop) n = {1'b0, bcnt} + 1'b1;
        else     n = (BC_W+1)'(BEAT_BYTES);
        return n;
    endfunction

    // Length accumulation that pins at the top of the range.
    function automatic logic [LEN_W-1:0] len_add(input logic [LEN_W-1:0] base, input logic [BC_W:0] inc);
        logic [LEN_W:0] sum;
        sum = {1'b0, base} + (LEN_W+1)'(inc);
        if (sum[LEN_W]) return {LEN_W{1'b1}};
        return sum[LEN_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input ch_cfg_t c);
        return DATA_W'(c);
    endfunction

    function automatic ch_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        return ch_cfg_t'(w[EN_BIT:0]);
    endfunction

endpackage

// File: rtl/pl_len_track.sv
module pl_len_track
    import pl_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_valid,
    input  logic             beat_sop,
    input  logic             beat_eop,
    input  logic [BC_W-1:0]  beat_bcnt,
    input  logic [CW-1:0]    beat_chan,
    output logic [LEN_W-1:0] len_now
);

    logic [LEN_W-1:0] partial [N_CH];
    logic [LEN_W-1:0] base;

    always_comb begin
        base    = beat_sop ? '0 : partial[beat_chan];
        len_now = len_add(base, beat_bytes(beat_eop, beat_bcnt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) partial[i] <= '0;
        end else if (beat_valid) begin
            partial[beat_chan] <= beat_eop ? '0 : len_now;
        end
    end

endmodule

// File: rtl/pl_limit_cmp.sv
module pl_limit_cmp
    import pl_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    input  ch_cfg_t          cfg,
    output logic             too_short,
    output logic             too_long
);

    always_comb begin
        too_short = len < LEN_W'(cfg.min_len);
        too_long  = len > LEN_W'(cfg.max_len);
    end

endmodule

// File: rtl/pl_cfg_regs.sv
module pl_cfg_regs
    import pl_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_chan,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CW-1:0]     beat_chan,
    input  logic [CW-1:0]     rd_chan,
    output ch_cfg_t           beat_cfg,
    output ch_cfg_t           rd_cfg
);

    ch_cfg_t table_q [N_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) table_q[i] <= '0;
        end else if (wr_en) begin
            table_q[wr_chan] <= word_to_cfg(wr_data);
        end
    end

    assign beat_cfg = table_q[beat_chan];
    assign rd_cfg   = table_q[rd_chan];

endmodule

// File: rtl/pl_err_counters.sv
module pl_err_counters
    import pl_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int N_KIND = 2,
    localparam int CW    = $clog2(N_CH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_KIND-1:0]            inc,
    input  logic [CW-1:0]                inc_chan,
    input  logic [N_KIND-1:0]            clr,
    input  logic [CW-1:0]                clr_chan,
    input  logic [CW-1:0]                rd_chan,
    output logic [N_KIND-1:0][CNT_W-1:0] rd_val
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    for (genvar k = 0; k < N_KIND; k++) begin : g_bank
        logic [CNT_W-1:0] cnt [N_CH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < N_CH; i++) cnt[i] <= '0;
            end else begin
                if (inc[k] && cnt[inc_chan] != CNT_TOP)
                    cnt[inc_chan] <= cnt[inc_chan] + 1'b1;
                if (clr[k])
                    cnt[clr_chan] <= '0;
            end
        end

        assign rd_val[k] = cnt[rd_chan];
    end

endmodule

// File: rtl/pkt_len_checker.sv
module pkt_len_checker
    import pl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BC_W-1:0]   in_bcnt,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [BC_W-1:0]   out_bcnt,
    output logic [CH_W-1:0]   out_chan,
    output logic [DATA_W-1:0] out_data,
    output logic              res_valid,
    output logic [CH_W-1:0]   res_chan,
    output logic              res_short,
    output logic              res_long,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    beat_t                 beat_in, beat_q;
    chk_res_t              res_d, res_q;
    ch_cfg_t               beat_cfg, rd_cfg;
    logic [LEN_W-1:0]      len_now;
    logic                  too_short, too_long;
    reg_sel_t              sel;
    logic [CH_W-1:0]       reg_chan;
    logic [1:0]            cnt_inc, cnt_clr;
    logic [1:0][CNT_W-1:0] cnt_rd;
    logic [DATA_W-1:0]     rd_mux;
    logic                  eop_beat;

    assign beat_in  = '{valid: in_valid, sop: in_sop, eop: in_eop,
                        bcnt: in_bcnt, chan: in_chan, data: in_data};
    assign sel      = reg_sel_t'(reg_addr[ADDR_W-1:CH_W]);
    assign reg_chan = reg_addr[CH_W-1:0];
    assign eop_beat = in_valid && in_eop;

    pl_len_track #(.N_CH(NUM_CH)) u_track (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (in_valid),
        .beat_sop   (in_sop),
        .beat_eop   (in_eop),
        .beat_bcnt  (in_bcnt),
        .beat_chan  (in_chan),
        .len_now    (len_now)
    );

    pl_cfg_regs #(.N_CH(NUM_CH)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr && sel == SEL_CFG),
        .wr_chan   (reg_chan),
        .wr_data   (reg_wdata),
        .beat_chan (in_chan),
        .rd_chan   (reg_chan),
        .beat_cfg  (beat_cfg),
        .rd_cfg    (rd_cfg)
    );

    pl_limit_cmp u_cmp (
        .len       (len_now),
        .cfg       (beat_cfg),
        .too_short (too_short),
        .too_long  (too_long)
    );

    always_comb begin
        cnt_inc[0] = eop_beat && beat_cfg.en && too_short;
        cnt_inc[1] = eop_beat && beat_cfg.en && too_long;
        cnt_clr[0] = reg_wr && sel == SEL_SHORT;
        cnt_clr[1] = reg_wr && sel == SEL_LONG;
    end

    pl_err_counters #(.N_CH(NUM_CH), .N_KIND(2)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .inc      (cnt_inc),
        .inc_chan (in_chan),
        .clr      (cnt_clr),
        .clr_chan (reg_chan),
        .rd_chan  (reg_chan),
        .rd_val   (cnt_rd)
    );

    always_comb begin
        res_d = '0;
        if (eop_beat) begin
            res_d.valid    = 1'b1;
            res_d.chan     = in_chan;
            res_d.is_short = too_short;
            res_d.is_long  = too_long;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CFG:   rd_mux = cfg_to_word(rd_cfg);
            SEL_SHORT: rd_mux = DATA_W'(cnt_rd[0]);
            SEL_LONG:  rd_mux = DATA_W'(cnt_rd[1]);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q    <= '0;
            res_q     <= '0;
            reg_rdata <= '0;
        end else begin
            beat_q <= beat_in;
            res_q  <= res_d;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    assign out_valid = beat_q.valid;
    assign out_sop   = beat_q.sop;
    assign out_eop   = beat_q.eop;
    assign out_bcnt  = beat_q.bcnt;
    assign out_chan  = beat_q.chan;
    assign out_data  = beat_q.data;
    assign res_valid = res_q.valid;
    assign res_chan  = res_q.chan;
    assign res_short = res_q.is_short;
    assign res_long  = res_q.is_long;

endmodule

// File: rtl/pkt_len_checker_sva.sv
module pkt_len_checker_sva
    import pl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_eop,
    input logic [CH_W-1:0]   in_chan,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              res_valid,
    input logic [CH_W-1:0]   res_chan,
    input logic              res_short,
    input logic              res_long,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata
);

    logic seen;
    always_ff @(posedge clk) seen <= !rst;

    p_strobe_timing_r9: assert property (@(posedge clk) disable iff (rst || !seen)
        res_valid == $past(in_valid && in_eop));

    p_strobe_chan_r9: assert property (@(posedge clk) disable iff (rst || !seen)
        res_valid |-> res_chan == $past(in_chan));

    p_quiet_flags_r9: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_short && !res_long));

    p_pass_data_r10: assert property (@(posedge clk) disable iff (rst || !seen)
        out_valid == $past(in_valid) && out_data == $past(in_data));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst || !seen)
        !$past(reg_rd) |-> $stable(reg_rdata));

    p_reset_quiet_r11: assert property (@(posedge clk)
        rst |=> (!res_valid && !out_valid && reg_rdata == '0));

endmodule

bind pkt_len_checker pkt_len_checker_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_eop    (in_eop),
    .in_chan   (in_chan),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .res_valid (res_valid),
    .res_chan  (res_chan),
    .res_short (res_short),
    .res_long  (res_long),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_pkt_len_checker.sv
`timescale 1ns/1ps
module sim_pkt_len_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 0, in_sop = 0, in_eop = 0;
    logic [1:0]  in_bcnt = 0;
    logic [7:0]  in_chan = 0;
    logic [31:0] in_data = 0;
    logic        out_valid, out_sop, out_eop;
    logic [1:0]  out_bcnt;
    logic [7:0]  out_chan;
    logic [31:0] out_data;
    logic        res_valid, res_short, res_long;
    logic [7:0]  res_chan;
    logic        reg_wr = 0, reg_rd = 0;
    logic [9:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;

    always #2 clk = ~clk;

    pkt_len_checker u0 (.*);

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // Reference model state
    int m_min [256], m_max [256], m_en [256], m_sc [256], m_lc [256], m_part [256];
    logic        e_ov, e_os, e_oe;
    logic [1:0]  e_ob;
    logic [7:0]  e_oc;
    logic [31:0] e_od;
    logic        e_rv, e_rs, e_rl;
    logic [7:0]  e_rc;
    logic [31:0] e_rd;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int i = 0; i < 256; i++) begin
                m_min[i] = 0; m_max[i] = 0; m_en[i] = 0;
                m_sc[i] = 0; m_lc[i] = 0; m_part[i] = 0;
            end
            {e_ov, e_os, e_oe, e_ob, e_oc, e_od} = '0;
            {e_rv, e_rs, e_rl, e_rc} = '0;
            e_rd = '0;
        end else begin
            int len, sel, ch;
            sel = reg_addr[9:8];
            ch  = reg_addr[7:0];
            // R12: read sees state from before this cycle's updates
            if (reg_rd) begin
                case (sel)
                    0: e_rd = (m_en[ch] << 22) | (m_max[ch] << 8) | m_min[ch];
                    1: e_rd = m_sc[ch];
                    2: e_rd = m_lc[ch];
                    default: e_rd = 0;
                endcase
            end
            {e_ov, e_os, e_oe, e_ob, e_oc, e_od} = {in_valid, in_sop, in_eop, in_bcnt, in_chan, in_data};
            {e_rv, e_rs, e_rl, e_rc} = '0;
            if (in_valid) begin
                len = (in_sop ? 0 : m_part[in_chan]) + (in_eop ? in_bcnt + 1 : 4);
                if (len > 32767) len = 32767;
                if (in_eop) begin
                    e_rv = 1; e_rc = in_chan;
                    e_rs = len < m_min[in_chan];
                    e_rl = len > m_max[in_chan];
                    if (m_en[in_chan] != 0) begin
                        if (e_rs && m_sc[in_chan] < 65535) m_sc[in_chan]++;
                        if (e_rl && m_lc[in_chan] < 65535) m_lc[in_chan]++;
                    end
                    m_part[in_chan] = 0;
                end else begin
                    m_part[in_chan] = len;
                end
            end
            // R8: clear after increment, so the write wins
            if (reg_wr) begin
                case (sel)
                    0: begin
                        m_min[ch] = reg_wdata[7:0];
                        m_max[ch] = reg_wdata[21:8];
                        m_en[ch]  = reg_wdata[22];
                    end
                    1: m_sc[ch] = 0;
                    2: m_lc[ch] = 0;
                    default: ;
                endcase
            end
        end
    end

    task automatic cmp(input string req, input string what, input longint act, input longint exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // One vector per cycle: outputs against the model, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            cmp("R10", "out_valid", out_valid, e_ov);
            cmp("R10", "out_sop",   out_sop,   e_os);
            cmp("R10", "out_eop",   out_eop,   e_oe);
            cmp("R10", "out_bcnt",  out_bcnt,  e_ob);
            cmp("R10", "out_chan",  out_chan,  e_oc);
            cmp("R10", "out_data",  out_data,  e_od);
            cmp("R9",  "res_valid", res_valid, e_rv);
            cmp("R9",  "res_chan",  res_chan,  e_rc);
            cmp("R1 R3 R4 R5", "res_short", res_short, e_rs);
            cmp("R2 R3 R4 R5", "res_long",  res_long,  e_rl);
            cmp("R6 R7 R8 R11 R12", "reg_rdata", reg_rdata, e_rd);
        end
    end

    task automatic idle();
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0; reg_wr = 0; reg_rd = 0;
    endtask

    task automatic beat(input int ch, input bit sop, input bit eop, input int bc);
        @(negedge clk);
        reg_wr = 0; reg_rd = 0;
        in_valid = 1; in_sop = sop; in_eop = eop;
        in_bcnt = 2'(bc); in_chan = 8'(ch); in_data = $urandom;
    endtask

    // Whole packet of len bytes (len >= 1) on one channel
    task automatic pkt(input int ch, input int len);
        int nb;
        nb = (len + 3) / 4;
        for (int b = 0; b < nb; b++)
            beat(ch, b == 0, b == nb - 1, (b == nb - 1) ? (len - 4 * (nb - 1) - 1) : 3);
    endtask

    task automatic wr(input int sel, input int ch, input logic [31:0] d);
        @(negedge clk);
        in_valid = 0; reg_rd = 0;
        reg_wr = 1; reg_addr = 10'((sel << 8) | ch); reg_wdata = d;
    endtask

    task automatic rd(input int sel, input int ch);
        @(negedge clk);
        in_valid = 0; reg_wr = 0;
        reg_rd = 1; reg_addr = 10'((sel << 8) | ch);
    endtask

    function automatic logic [31:0] cfg(input int mn, input int mx, input bit en);
        return (32'(en) << 22) | (32'(mx) << 8) | 32'(mn);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R11: reset state of config and counters
        rd(0, 5); rd(1, 5); rd(2, 200); rd(3, 7); idle();

        // R1 R2 R3 R4: limits 10..20 on channel 1, enabled
        wr(0, 1, cfg(10, 20, 1)); rd(0, 1);
        pkt(1, 9); pkt(1, 10); pkt(1, 20); pkt(1, 21); pkt(1, 1); pkt(1, 17);
        idle(); rd(1, 1); rd(2, 1); idle();

        // R4: SOP inside an open packet restarts the count
        beat(1, 1, 0, 3); beat(1, 0, 0, 3); beat(1, 1, 0, 3); beat(1, 0, 1, 1);
        idle(); rd(1, 1);

        // R5: interleaved channels 2 and 3
        wr(0, 2, cfg(12, 12, 1)); wr(0, 3, cfg(0, 8, 1));
        beat(2, 1, 0, 3); beat(3, 1, 0, 3); beat(2, 0, 0, 3); beat(3, 0, 1, 3);
        beat(2, 0, 1, 3); beat(3, 1, 0, 3); beat(3, 0, 0, 3); beat(3, 0, 1, 0);
        idle(); rd(1, 2); rd(2, 2); rd(2, 3);

        // R6: enable clear, flags still reported, counters stay
        wr(0, 4, cfg(200, 5, 0));
        pkt(4, 4); pkt(4, 60); idle(); rd(1, 4); rd(2, 4);

        // R2 R3: widest maximum against 16383 and 16384 bytes
        wr(0, 6, cfg(0, 16383, 1));
        pkt(6, 16383); pkt(6, 16384); pkt(6, 16383);
        idle(); rd(2, 6); rd(0, 6);

        // R8: clear, and clear colliding with an increment
        wr(1, 1, 0); rd(1, 1);
        beat(1, 1, 1, 0);
        @(negedge clk);
        in_valid = 1; in_sop = 1; in_eop = 1; in_bcnt = 0; in_chan = 1;
        reg_wr = 1; reg_addr = 10'h101; reg_rd = 0;
        idle(); rd(1, 1); rd(2, 1);

        // R7: saturation of the short counter on channel 7
        wr(0, 7, cfg(255, 300, 1));
        for (int i = 0; i < 65540; i++) beat(7, 1, 1, 3);
        idle(); rd(1, 7);
        pkt(7, 2); idle(); rd(1, 7);

        // Mixed traffic over channels 8..11 with arbitrary limits
        for (int c = 8; c < 12; c++) wr(0, c, cfg($urandom_range(0, 40), $urandom_range(0, 60), 1));
        for (int i = 0; i < 400; i++) begin
            int c;
            c = 8 + $urandom_range(0, 3);
            if ($urandom_range(0, 4) == 0) rd($urandom_range(0, 3), c);
            else beat(c, $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 3));
        end
        idle();
        for (int c = 8; c < 12; c++) begin rd(1, c); rd(2, c); end
        idle(); idle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule